// File: doc/BRIEF.md
# Two-Stage Error Status Register

This block is the error status register of an interrupt controller. It holds error state in two stages. A hidden accumulator collects sticky bits from a vector of hardware error pulses. A software-visible latch changes only when software writes the register. A write moves the accumulator into the latch and empties the accumulator in the same cycle, so a read shows the errors captured at the last write. The error interrupt request is built from the hidden accumulator alone.

Software that wants a zero reading must issue two writes in a row. The first write empties the accumulator. The second copies those zeros into the latch. An error that arrives between the two writes is still visible after the second one. For that reason the only reliable way to confirm a clean state is to repeat write-then-read until the read gives zero.

A mode input selects an older behaviour. In that mode a read returns the live accumulator and clears it, and writes do nothing. The register bus carries no write data, because the written value never matters. Read data is registered and appears in the cycle after the read strobe.

Top module: `err_status_reg`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the latch, `rdata` and `irq` to zero.
- R2: Each `err_pulse` bit that is high at a clock edge sets the matching accumulator bit. That bit stays set until a clearing access.
- R3: With `legacy_mode` low, a selected write copies the accumulator into the latch and clears the accumulator at the same edge.
- R4: With `legacy_mode` low, a selected read loads the latch into `rdata` bits 7:0 in the cycle after the strobe. Bits 31:8 read as zero. Neither the latch nor the accumulator changes.
- R5: Two back-to-back writes make a following read return zero. An error that arrives between those writes is returned by the read after the second write.
- R6: `irq` equals, one cycle late, `irq_en` ANDed with the OR of the accumulator bits. The latch contents have no influence on it.
- R7: With `legacy_mode` high, a selected read returns the accumulator and then clears it. Writes change neither stage.
- R8: An error pulse in the same cycle as a clearing write or a clearing legacy read is kept in the accumulator. The old contents are moved or returned.
- R9: Strobes with `sel` low have no effect on either stage or on `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Register select |
| wr_en | input | 1 | Write strobe (no data carried) |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data, error field in bits 7:0 |
| err_pulse | input | 8 | Single-cycle error event inputs |
| irq_en | input | 1 | Error interrupt enable |
| legacy_mode | input | 1 | 1 = read-to-clear mode, 0 = two-stage mode |
| irq | output | 1 | Registered error interrupt request |

## Verification
The critical collision is an error pulse that lands in the same cycle as a clearing access. That access is a write in two-stage mode or a read in legacy mode. The bench provokes both cases by driving a pulse together with the strobe. It then reads the register twice. The first read must show only the old contents and the second read must show only the new bit. A second overlap is the interrupt path: the accumulator empties while the latch still holds errors. The check there is that `irq` drops in the following cycle even though a read still returns the nonzero latch.

// File: rtl/errlatch_pkg.sv
package errlatch_pkg;
  localparam int DEF_ERR_W  = 8;
  localparam int DEF_DATA_W = 32;

  typedef struct packed {
    logic move;   // two-stage write: accumulator -> latch, then clear
    logic rdclr;  // legacy read: return accumulator and clear it
    logic rd;     // any selected read
  } acc_ctl_t;
endpackage

// File: rtl/err_bus_decode.sv
module err_bus_decode
  import errlatch_pkg::*;
(
  input  logic     sel,
  input  logic     wr_en,
  input  logic     rd_en,
  input  logic     legacy_mode,
  output acc_ctl_t ctl
);
  always_comb begin
    ctl.move  = sel & wr_en & ~legacy_mode;
    ctl.rdclr = sel & rd_en & legacy_mode;
    ctl.rd    = sel & rd_en;
  end
endmodule

// File: rtl/err_accum.sv
module err_accum
  import errlatch_pkg::*;
#(
  parameter int ERR_W = DEF_ERR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  acc_ctl_t         ctl,
  input  logic [ERR_W-1:0] err_pulse,
  output logic [ERR_W-1:0] acc_q
);
  logic clear_now;
  assign clear_now = ctl.move | ctl.rdclr;

  for (genvar b = 0; b < ERR_W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)            acc_q[b] <= 1'b0;
      else if (clear_now) acc_q[b] <= err_pulse[b];
      else                acc_q[b] <= acc_q[b] | err_pulse[b];
    end
  end
endmodule

// File: rtl/err_view_latch.sv
module err_view_latch
  import errlatch_pkg::*;
#(
  parameter int ERR_W  = DEF_ERR_W,
  parameter int DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  acc_ctl_t          ctl,
  input  logic              legacy_mode,
  input  logic [ERR_W-1:0]  acc_q,
  output logic [ERR_W-1:0]  latch_q,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_W = DATA_W - ERR_W;

  logic [ERR_W-1:0] rd_src;
  assign rd_src = legacy_mode ? acc_q : latch_q;

  always_ff @(posedge clk) begin
    if (rst)           latch_q <= '0;
    else if (ctl.move) latch_q <= acc_q;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (ctl.rd) rdata <= {{PAD_W{1'b0}}, rd_src};
  end
endmodule

// File: rtl/err_irq_gen.sv
module err_irq_gen #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_en,
  input  logic [ERR_W-1:0] acc_q,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= irq_en & (|acc_q);
  end
endmodule

// File: rtl/err_status_reg.sv
module err_status_reg
  import errlatch_pkg::*;
#(
  parameter int ERR_W  = DEF_ERR_W,
  parameter int DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  input  logic [ERR_W-1:0]  err_pulse,
  input  logic              irq_en,
  input  logic              legacy_mode,
  output logic              irq
);
  acc_ctl_t         ctl;
  logic [ERR_W-1:0] acc_q;
  logic [ERR_W-1:0] latch_q;

  err_bus_decode u_dec (
    .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
    .legacy_mode(legacy_mode), .ctl(ctl)
  );

  err_accum #(.ERR_W(ERR_W)) u_acc (
    .clk(clk), .rst(rst), .ctl(ctl), .err_pulse(err_pulse), .acc_q(acc_q)
  );

  err_view_latch #(.ERR_W(ERR_W), .DATA_W(DATA_W)) u_view (
    .clk(clk), .rst(rst), .ctl(ctl), .legacy_mode(legacy_mode),
    .acc_q(acc_q), .latch_q(latch_q), .rdata(rdata)
  );

  err_irq_gen #(.ERR_W(ERR_W)) u_irq (
    .clk(clk), .rst(rst), .irq_en(irq_en), .acc_q(acc_q), .irq(irq)
  );
endmodule

// File: rtl/err_status_chk.sv
module err_status_chk #(
  parameter int ERR_W  = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              sel,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] rdata,
  input logic [ERR_W-1:0]  err_pulse,
  input logic              irq_en,
  input logic              legacy_mode,
  input logic              irq,
  input logic [ERR_W-1:0]  acc,
  input logic [ERR_W-1:0]  latch
);
  logic mv, rc;
  assign mv = sel && wr_en && !legacy_mode;
  assign rc = sel && rd_en && legacy_mode;

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (irq == 1'b0 && rdata == '0 && acc == '0 && latch == '0)); // R1
  AST_STICKY_BITS: assert property (@(posedge clk) disable iff (rst) (!mv && !rc) |=> ((acc & $past(acc)) == $past(acc))); // R2
  AST_WRITE_MOVES: assert property (@(posedge clk) disable iff (rst) mv |=> (latch == $past(acc))); // R3
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst) !mv |=> $stable(latch)); // R4
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst) rdata[DATA_W-1:ERR_W] == '0); // R4
  AST_IRQ_FROM_ACC: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (irq == ($past(irq_en) && ($past(acc) != '0)))); // R6
  AST_LEGACY_READ: assert property (@(posedge clk) disable iff (rst) rc |=> (rdata[ERR_W-1:0] == $past(acc))); // R7
  AST_CLEAR_KEEPS_NEW: assert property (@(posedge clk) disable iff (rst) (mv || rc) |=> (acc == $past(err_pulse))); // R8
endmodule

bind err_status_reg err_status_chk #(.ERR_W(ERR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
  .rdata(rdata), .err_pulse(err_pulse), .irq_en(irq_en),
  .legacy_mode(legacy_mode), .irq(irq), .acc(acc_q), .latch(latch_q)
);

// File: tb/err_status_reg_tb.sv
module err_status_reg_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] rdata;
  logic [7:0]  err_pulse = '0;
  logic        irq_en = 1'b1, legacy_mode = 1'b0;
  logic        irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  err_status_reg u_dut (
    .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
    .rdata(rdata), .err_pulse(err_pulse), .irq_en(irq_en),
    .legacy_mode(legacy_mode), .irq(irq)
  );

  // op[17:16]: 0 idle, 1 write, 2 read ; pulse[15:8] ; expected read byte[7:0]
  localparam logic [17:0] VEC [0:10] = '{
    {2'd0, 8'h01, 8'h00},  // R2 accumulate
    {2'd0, 8'h04, 8'h00},  // R2
    {2'd2, 8'h00, 8'h00},  // R4 latch still empty
    {2'd1, 8'h00, 8'h00},  // R3 move 05
    {2'd2, 8'h00, 8'h05},  // R3/R4
    {2'd2, 8'h10, 8'h05},  // R4 read does not disturb
    {2'd1, 8'h20, 8'h00},  // R8 pulse with write
    {2'd2, 8'h00, 8'h10},  // R3
    {2'd1, 8'h00, 8'h00},  // R5 first write: latch 20
    {2'd1, 8'h00, 8'h00},  // R5 second write
    {2'd2, 8'h00, 8'h00}   // R5 reads zero
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic s, input logic w, input logic r, input logic [7:0] p);
    sel = s; wr_en = w; rd_en = r; err_pulse = p;
    @(negedge clk);
    sel = 1'b0; wr_en = 1'b0; rd_en = 1'b0; err_pulse = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    for (int i = 0; i < 11; i++) begin
      op(1'b1, VEC[i][17:16] == 2'd1, VEC[i][17:16] == 2'd2, VEC[i][15:8]);
      if (VEC[i][17:16] == 2'd2) chk("R3/R4/R5/R8 vector read", rdata, {24'h0, VEC[i][7:0]});
    end

    // R5: error between the two writes survives
    op(1'b0, 1'b0, 1'b0, 8'h02);
    op(1'b1, 1'b1, 1'b0, 8'h00);
    op(1'b0, 1'b0, 1'b0, 8'h40);
    op(1'b1, 1'b1, 1'b0, 8'h00);
    op(1'b1, 1'b0, 1'b1, 8'h00);
    chk("R5 late error visible", rdata, 32'h40);

    // R6 irq timing and independence from latch
    do_reset();
    op(1'b0, 1'b0, 1'b0, 8'h02);
    chk("R6 irq not yet", {31'h0, irq}, 32'h0);
    op(1'b0, 1'b0, 1'b0, 8'h00);
    chk("R6 irq raised", {31'h0, irq}, 32'h1);
    irq_en = 1'b0;
    op(1'b0, 1'b0, 1'b0, 8'h00);
    chk("R6 irq masked", {31'h0, irq}, 32'h0);
    irq_en = 1'b1;
    op(1'b1, 1'b1, 1'b0, 8'h00);
    op(1'b0, 1'b0, 1'b0, 8'h00);
    chk("R6 irq low with latch set", {31'h0, irq}, 32'h0);
    op(1'b1, 1'b0, 1'b1, 8'h00);
    chk("R6 latch still holds", rdata, 32'h02);

    // R9 unselected strobes
    do_reset();
    op(1'b0, 1'b0, 1'b0, 8'h04);
    op(1'b0, 1'b1, 1'b0, 8'h00);
    op(1'b0, 1'b0, 1'b1, 8'h00);
    chk("R9 rdata unchanged", rdata, 32'h0);
    op(1'b1, 1'b0, 1'b1, 8'h00);
    chk("R9 latch unchanged", rdata, 32'h0);
    op(1'b1, 1'b1, 1'b0, 8'h00);
    op(1'b1, 1'b0, 1'b1, 8'h00);
    chk("R9 accumulator kept", rdata, 32'h04);

    // R7 / R8 legacy mode
    do_reset();
    legacy_mode = 1'b1;
    op(1'b0, 1'b0, 1'b0, 8'h03);
    op(1'b1, 1'b0, 1'b1, 8'h00);
    chk("R7 legacy read live", rdata, 32'h03);
    op(1'b1, 1'b0, 1'b1, 8'h00);
    chk("R7 legacy read cleared", rdata, 32'h00);
    op(1'b0, 1'b0, 1'b0, 8'h08);
    op(1'b1, 1'b1, 1'b0, 8'h00);
    op(1'b1, 1'b0, 1'b1, 8'h00);
    chk("R7 legacy write no effect", rdata, 32'h08);
    op(1'b0, 1'b0, 1'b0, 8'h80);
    op(1'b1, 1'b0, 1'b1, 8'h40);
    chk("R8 legacy read old bits", rdata, 32'h80);
    op(1'b1, 1'b0, 1'b1, 8'h00);
    chk("R8 legacy new bit kept", rdata, 32'h40);
    legacy_mode = 1'b0;
    op(1'b1, 1'b0, 1'b1, 8'h00);
    chk("R7 latch untouched by legacy", rdata, 32'h00);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule